// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache between one requester and a slower memory. Each address selects one set. The requested block may be held in either of that set's two ways. Both stored tags of the set are compared at once. The way that matches drives a two-input mux that delivers the line, and the requested byte is then taken from that line.

A hit returns the byte one cycle after the request is accepted. A miss stalls the requester and fetches the whole line over a request/response memory port. The line is written into an empty way of the set if one exists. If both ways are full, the way used least recently is replaced. A single bit per set records which way to replace next.

Top module: `cache2w_top`

## Requirements
- R1: After reset every line is invalid, `rd_ready` is 1, and `mem_req` and `rd_data_valid` are 0. The first access to any block misses.
- R2: The address is split into three fields. The byte offset is `addr[3:0]`, the set index is `addr[5:4]` and the tag is `addr[15:6]`. `mem_addr` carries the block address `addr[15:4]`, so byte address 6195 requests block 387, which lands in set 3.
- R3: One comparator per way checks the stored valid bit and tag against the lookup tag. A hit is the OR of the two results, and at most one way ever matches.
- R4: On a hit, `rd_data` is the byte at the requested offset of the matching way's line. `rd_data_valid` is high in the cycle after acceptance, and no memory request is made.
- R5: On a miss, `rd_ready` drops and `mem_req` rises. `mem_addr` holds the block address steady until `mem_rsp_valid` arrives.
- R6: The response line holds byte k in bits `[8k+7:8k]`. It is written into the chosen way and that way is marked valid. The requested byte comes back with `rd_data_valid` in the cycle after the response, and `rd_ready` returns to 1.
- R7: A miss fills an invalid way of the set when there is one. When both ways are invalid, way 0 is filled first.
- R8: When both ways of the set are valid, the way named by the set's replacement bit is evicted. Every hit and every fill points that bit at the other way.
- R9: When two blocks of the same set are accessed in alternation, every access after the first two hits.
- R10: A `mem_rsp_valid` pulse while no miss is pending is ignored. It causes no output and changes no cached line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | 16 | Byte address of the read |
| rd_ready | output | 1 | Request accepted when high with `rd_valid` |
| rd_data_valid | output | 1 | One-cycle pulse marking returned data |
| rd_data | output | 8 | Returned byte |
| mem_req | output | 1 | Line fetch pending |
| mem_addr | output | 12 | Block address of the fetch |
| mem_rsp_valid | input | 1 | Fetched line present |
| mem_rsp_line | input | 128 | Fetched line, byte k at bits 8k+7..8k |

## Verification
The assertions run on every cycle and cover four properties:
- at most one way matches a lookup;
- a hit is answered on the next cycle, and a miss raises a fetch;
- the fetch address stays steady while it waits;
- a fill marks its way valid and never evicts a live way while an empty one exists.

Only the bench scenarios can show end-to-end behaviour. These include which resident block a later miss actually evicts over a long access history, that alternating conflict blocks keep hitting, that the right byte comes out of each offset, and that a stray memory response leaves cached contents untouched.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef enum logic {ST_IDLE, ST_FILL} cache_st_t;

  // byte position inside a line
  function automatic int unsigned offset_of(int unsigned addr, int unsigned off_w);
    return addr & ((32'd1 << off_w) - 32'd1);
  endfunction

  // block number = address divided by line size
  function automatic int unsigned block_of(int unsigned addr, int unsigned off_w);
    return addr >> off_w;
  endfunction

  // set = block number modulo set count
  function automatic int unsigned set_of(int unsigned addr, int unsigned off_w, int unsigned set_w);
    return block_of(addr, off_w) & ((32'd1 << set_w) - 32'd1);
  endfunction

  // tag = bits above offset and set
  function automatic int unsigned tag_of(int unsigned addr, int unsigned off_w, int unsigned set_w);
    return block_of(addr, off_w) >> set_w;
  endfunction

endpackage

// File: rtl/cache2w_way_cmp.sv
module cache2w_way_cmp #(
  parameter int TAG_W = 10
) (
  input  logic             way_valid,
  input  logic [TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0] look_tag,
  output logic             match
);
  always_comb match = way_valid && (way_tag == look_tag);
endmodule

// File: rtl/cache2w_victim.sv
module cache2w_victim (
  input  logic valid0,
  input  logic valid1,
  input  logic lru_way,
  output logic victim
);
  always_comb begin
    if (!valid0)      victim = 1'b0;
    else if (!valid1) victim = 1'b1;
    else              victim = lru_way;
  end
endmodule

// File: rtl/cache2w_byte_sel.sv
module cache2w_byte_sel #(
  parameter int OFF_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [(BYTE_W<<OFF_W)-1:0] line,
  input  logic [OFF_W-1:0]           off,
  output logic [BYTE_W-1:0]          byte_out
);
  always_comb byte_out = line[off*BYTE_W +: BYTE_W];
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_valid,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic                            rd_ready,
  output logic                            rd_data_valid,
  output logic [BYTE_W-1:0]               rd_data,
  output logic                            mem_req,
  output logic [ADDR_W-OFF_W-1:0]         mem_addr,
  input  logic                            mem_rsp_valid,
  input  logic [(BYTE_W<<OFF_W)-1:0]      mem_rsp_line
);
  import cache2w_pkg::*;

  localparam int SETS   = 1 << SET_W;
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int LINE_W = BYTE_W << OFF_W;
  localparam int WAYS   = 2;

  cache_st_t state_q;

  logic [WAYS-1:0]   valid_q [SETS];
  logic              lru_q   [SETS];
  logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
  logic [LINE_W-1:0] line_q  [WAYS][SETS];
  logic [ADDR_W-1:0] pend_addr_q;

  // lookup fields of the incoming request
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [OFF_W-1:0] lk_off;
  always_comb begin
    lk_set = SET_W'(set_of(32'(rd_addr), OFF_W, SET_W));
    lk_tag = TAG_W'(tag_of(32'(rd_addr), OFF_W, SET_W));
    lk_off = OFF_W'(offset_of(32'(rd_addr), OFF_W));
  end

  // fields of the pending miss
  logic [SET_W-1:0] pset;
  logic [TAG_W-1:0] ptag;
  logic [OFF_W-1:0] poff;
  always_comb begin
    pset = SET_W'(set_of(32'(pend_addr_q), OFF_W, SET_W));
    ptag = TAG_W'(tag_of(32'(pend_addr_q), OFF_W, SET_W));
    poff = OFF_W'(offset_of(32'(pend_addr_q), OFF_W));
  end

  // named events
  logic [WAYS-1:0] hit_vec;
  logic            lookup_hit;
  logic            hit_way;
  logic            req_fire;
  logic            fill_fire;
  logic            vict_way;
  logic [LINE_W-1:0] hit_line;
  logic [BYTE_W-1:0] hit_byte;
  logic [BYTE_W-1:0] fill_byte;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache2w_way_cmp #(.TAG_W(TAG_W)) u_cmp (
      .way_valid (valid_q[lk_set][w]),
      .way_tag   (tag_q[w][lk_set]),
      .look_tag  (lk_tag),
      .match     (hit_vec[w])
    );
  end

  always_comb begin
    lookup_hit = |hit_vec;
    hit_way    = hit_vec[1];
    hit_line   = hit_way ? line_q[1][lk_set] : line_q[0][lk_set];
    req_fire   = rd_valid && rd_ready;
    fill_fire  = (state_q == ST_FILL) && mem_rsp_valid;
  end

  cache2w_victim u_victim (
    .valid0 (valid_q[pset][0]),
    .valid1 (valid_q[pset][1]),
    .lru_way(lru_q[pset]),
    .victim (vict_way)
  );

  cache2w_byte_sel #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_hit_sel (
    .line(hit_line), .off(lk_off), .byte_out(hit_byte)
  );

  cache2w_byte_sel #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_fill_sel (
    .line(mem_rsp_line), .off(poff), .byte_out(fill_byte)
  );

  // control, valid bits and replacement bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      pend_addr_q   <= '0;
      rd_data_valid <= 1'b0;
      rd_data       <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        lru_q[s]   <= 1'b0;
      end
    end else begin
      rd_data_valid <= 1'b0;
      if (req_fire) begin
        if (lookup_hit) begin
          rd_data_valid  <= 1'b1;
          rd_data        <= hit_byte;
          lru_q[lk_set]  <= ~hit_way;
        end else begin
          pend_addr_q <= rd_addr;
          state_q     <= ST_FILL;
        end
      end
      if (fill_fire) begin
        valid_q[pset][vict_way] <= 1'b1;
        lru_q[pset]             <= ~vict_way;
        rd_data_valid           <= 1'b1;
        rd_data                 <= fill_byte;
        state_q                 <= ST_IDLE;
      end
    end
  end

  // tag and data arrays, no reset needed
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[vict_way][pset]  <= ptag;
      line_q[vict_way][pset] <= mem_rsp_line;
    end
  end

  always_comb begin
    rd_ready = (state_q == ST_IDLE);
    mem_req  = (state_q == ST_FILL);
    mem_addr = (ADDR_W-OFF_W)'(block_of(32'(pend_addr_q), OFF_W));
  end

  AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && lookup_hit |=> rd_data_valid && !mem_req); // R4

  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !lookup_hit |=> mem_req && !rd_ready); // R5

  AST_FETCH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr)); // R5

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> valid_q[$past(pset)][$past(vict_way)] && rd_data_valid); // R6

  AST_EMPTY_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && !(&valid_q[pset]) |-> !valid_q[pset][vict_way]); // R7

  AST_STRAY_RSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && !mem_req && !(req_fire && lookup_hit) |=> !rd_data_valid); // R10

endmodule

// File: tb/tb_cache2w_top.sv
module tb_cache2w_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_valid = 1'b0;
  logic [15:0]  rd_addr = '0;
  logic         rd_ready;
  logic         rd_data_valid;
  logic [7:0]   rd_data;
  logic         mem_req;
  logic [11:0]  mem_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_line = '0;

  cache2w_top dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int fills    = 0;
  int acc_cyc  = 0;
  int exp_blk  = 0;
  bit stray    = 1'b0;
  bit done     = 1'b0;

  typedef struct {
    logic [7:0] data;
    bit         hit;
    int         fills_after;
    string      req;
  } item_t;
  item_t sb[$];

  // reference model state, per requirement R7/R8
  bit mv [4][2];
  int mt [4][2];
  bit mlru [4];

  function automatic logic [7:0] mbyte(int blk, int k);
    return 8'((blk * 7 + k * 13 + 5) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: answers each fetch after a fixed latency
  initial begin
    forever begin
      @(negedge clk);
      if (stray) begin
        mem_rsp_line  = '1;
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        stray = 1'b0;
      end else if (mem_req) begin
        int blk;
        blk = int'(mem_addr);
        fills++;
        chk(mem_addr == 12'(exp_blk), "R2", "fetch block address", blk, exp_blk);
        chk(!rd_ready, "R5", "ready low during miss", int'(rd_ready), 0);
        repeat (MEM_LAT) @(negedge clk);
        chk(mem_req && mem_addr == 12'(exp_blk), "R5", "fetch held", int'(mem_addr), exp_blk);
        for (int k = 0; k < 16; k++) mem_rsp_line[k*8 +: 8] = mbyte(blk, k);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // monitor: pops the scoreboard when data comes back
  always @(negedge clk) begin
    if (rst_n && rd_data_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10", "unexpected data pulse", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(rd_data == it.data, it.req, "returned byte", int'(rd_data), int'(it.data));
        chk(fills == it.fills_after, it.req, "fetch count (hit/miss)", fills, it.fills_after);
        if (it.hit)
          chk(cyc == acc_cyc, "R4", "hit latency", cyc - acc_cyc, 0);
      end
    end
  end

  // driver: predicts the outcome from the requirements and issues the read
  task automatic rd(input int a, input string req);
    int set, tag, blk, w;
    bit hit;
    item_t it;
    set = (a >> 4) & 3;
    tag = a >> 6;
    blk = a >> 4;
    hit = 1'b0;
    w = 0;
    for (int i = 0; i < 2; i++)
      if (mv[set][i] && mt[set][i] == tag) begin hit = 1'b1; w = i; end
    if (!hit) begin
      if (!mv[set][0])      w = 0;
      else if (!mv[set][1]) w = 1;
      else                  w = int'(mlru[set]);
      mv[set][w] = 1'b1;
      mt[set][w] = tag;
    end
    mlru[set] = (w == 0);
    while (!rd_ready) @(negedge clk);
    exp_blk        = blk;
    it.data        = mbyte(blk, a & 15);
    it.hit         = hit;
    it.fills_after = fills + (hit ? 0 : 1);
    it.req         = req;
    sb.push_back(it);
    rd_valid = 1'b1;
    rd_addr  = 16'(a);
    @(posedge clk);
    #1 acc_cyc = cyc;
    @(negedge clk);
    rd_valid = 1'b0;
    if (!hit) while (sb.size() != 0) @(negedge clk);
  endtask

  localparam int A = 16'h0040;  // set 0, tag 1
  localparam int B = 16'h0080;  // set 0, tag 2
  localparam int C = 16'h00C0;  // set 0, tag 3
  localparam int D = 16'h0010;  // set 1

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_ready == 1'b1, "R1", "ready after reset", int'(rd_ready), 1);
    chk(mem_req == 1'b0, "R1", "no fetch after reset", int'(mem_req), 0);
    chk(rd_data_valid == 1'b0, "R1", "no data after reset", int'(rd_data_valid), 0);

    rd(A + 3, "R1");          // first access misses, fills way 0 (R7)
    rd(A + 5, "R4");          // hit, other offset
    rd(B + 2, "R7");          // second block goes to empty way 1
    for (int i = 0; i < 3; i++) begin
      rd(A + i, "R9");
      rd(B + 15 - i, "R9");
    end
    rd(A + 1, "R3");          // hit in way 0 only
    rd(C + 7, "R8");          // both valid: evicts B
    rd(A + 9, "R8");          // A still resident
    rd(B + 4, "R8");          // B gone: evicts C
    rd(C + 0, "R8");          // evicts A
    rd(A + 12, "R8");         // misses again
    rd(D + 6, "R6");          // other set, empty
    rd(6195, "R2");           // block 387, set 3
    rd(6196, "R2");           // same block hit

    // stray response while idle must be ignored
    while (!rd_ready) @(negedge clk);
    stray = 1'b1;
    while (stray) @(negedge clk);
    @(negedge clk);
    chk(rd_data_valid == 1'b0, "R10", "no data from stray response", int'(rd_data_valid), 0);
    chk(rd_ready == 1'b1, "R10", "still idle after stray", int'(rd_ready), 1);
    rd(D + 6, "R10");         // cached line unchanged
    rd(6195, "R10");

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R6", "all results returned", sb.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule